// File: doc/BRIEF.md
# CAN Receive Match Winner Arbiter

Once the length field of an incoming CAN frame has been taken in, the controller has to pick one storage target for that frame. This block makes that pick. It looks at a parameterised bank of receive mailboxes and at one receive FIFO. For each mailbox it takes an identifier-match flag, a 4-bit status code and a read-and-unlocked flag. For the FIFO it takes a match flag and a full flag. Configuration bits choose which side is searched first, whether occupied mailboxes queue into the FIFO, whether the FIFO is enabled at all, and how remote frames are stored. Identifier filtering happens elsewhere; the match flags arrive here already computed.

The decision is registered. One clock after the trigger, a single-cycle valid pulse comes out together with exactly one outcome: a mailbox index (with an overrun flag when that mailbox was already occupied), the FIFO, a FIFO overflow, or a dropped frame. Between results every outcome output is held at zero.

Top module: `can_rx_winner_arb`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: A high `dlc_done_i` at a rising edge produces `res_valid_o`=1 for exactly the next cycle, carrying the decision made from the inputs sampled at that edge. With no trigger, `res_valid_o` and every outcome output read 0.
- R3: When `res_valid_o`=1, exactly one of `win_mb_o`, `win_fifo_o`, `fifo_ovf_o` and `drop_o` is 1. `mb_ovr_o` may be 1 only together with `win_mb_o`.
- R4: For a data frame (`is_remote_i`=0), or for a remote frame with `rmt_store_i`=1, a matched mailbox is free when its code is EMPTY (4'h4), or when its code is FULL (4'h2) or OVERRUN (4'h6) and its `mb_unlocked_i` bit is 1.
- R5: For a remote frame with `rmt_store_i`=0, a matched mailbox is free only when its code is RANSWER (4'hA). In every case, a mailbox whose code is not one of 4'h4, 4'h2, 4'h6 or 4'hA never takes part. A matched, participating mailbox that is not free counts as occupied.
- R6: The mailbox search runs when `mb_first_i`=1, when the FIFO is disabled, or when the FIFO-first check fails. If any matched mailbox is free, the lowest-index free one wins with `mb_ovr_o`=0.
- R7: If no matched mailbox is free, at least one is occupied, and `queue_en_i`=0, the lowest-index occupied mailbox wins with `mb_ovr_o`=1.
- R8: If no matched mailbox is free, at least one is occupied, and `queue_en_i`=1, the FIFO wins when it is enabled, matched and not full. Otherwise the highest-index occupied mailbox wins with `mb_ovr_o`=1.
- R9: If no mailbox takes part with a match and the FIFO is enabled and matched, the FIFO wins when it is not full and `fifo_ovf_o` is raised when it is full. If the FIFO is unmatched or disabled, `drop_o` is raised, whatever the full flag says.
- R10: With `mb_first_i`=0 and the FIFO enabled, an enabled, matched, not-full FIFO wins whatever the mailbox state is.
- R11: With `fifo_en_i`=0, `fifo_match_i`, `fifo_full_i` and `mb_first_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| dlc_done_i | input | 1 | Trigger: length field of the frame received |
| is_remote_i | input | 1 | Frame is a remote frame |
| mb_match_i | input | NUM_MB | Per-mailbox identifier match |
| mb_code_i | input | 4*NUM_MB | Per-mailbox status code, mailbox i at bits [4i+3:4i] |
| mb_unlocked_i | input | NUM_MB | Per-mailbox: already read and unlocked |
| fifo_en_i | input | 1 | Receive FIFO enabled |
| fifo_match_i | input | 1 | FIFO filter match |
| fifo_full_i | input | 1 | FIFO has no free slot |
| mb_first_i | input | 1 | 1: mailboxes searched before the FIFO |
| queue_en_i | input | 1 | 1: occupied mailboxes fall back to the FIFO |
| rmt_store_i | input | 1 | 1: remote frames are stored like data frames |
| res_valid_o | output | 1 | One-cycle result strobe |
| win_mb_o | output | 1 | A mailbox won |
| win_idx_o | output | IDX_W | Index of the winning mailbox |
| mb_ovr_o | output | 1 | The winning mailbox was occupied (overrun) |
| win_fifo_o | output | 1 | The FIFO won |
| fifo_ovf_o | output | 1 | FIFO matched but full |
| drop_o | output | 1 | Frame not stored |

## Verification
Two functions can land in the same clock cycle. First, a result can be presented on the same cycle that the next trigger is captured: the bench applies back-to-back triggers with different mailbox states, and each pulse must carry the decision for its own frame, never a stale one. Second, the overrun decision and the FIFO-full condition can meet when queueing is on and every matched mailbox is occupied. The bench builds these cases with both FIFO-full polarities and accepts only the highest-index overrun for a full FIFO and the FIFO for a free one, never an overflow. A behavioural reference model, run every cycle alongside long random streams, judges both cases.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;

  localparam logic [3:0] MB_CODE_EMPTY   = 4'h4;
  localparam logic [3:0] MB_CODE_FULL    = 4'h2;
  localparam logic [3:0] MB_CODE_OVERRUN = 4'h6;
  localparam logic [3:0] MB_CODE_RANSWER = 4'hA;

  typedef enum logic [2:0] {
    OUT_NONE = 3'd0,
    OUT_MB   = 3'd1,
    OUT_FIFO = 3'd2,
    OUT_OVF  = 3'd3,
    OUT_DROP = 3'd4
  } arb_out_e;

endpackage

// File: rtl/can_mb_classify.sv
module can_mb_classify
  import can_arb_pkg::*;
#(
  parameter int NUM_MB = 16
) (
  input  logic [NUM_MB-1:0]   match_i,
  input  logic [4*NUM_MB-1:0] code_i,
  input  logic [NUM_MB-1:0]   unlocked_i,
  input  logic                is_remote_i,
  input  logic                rmt_store_i,
  output logic [NUM_MB-1:0]   free_o,
  output logic [NUM_MB-1:0]   occ_o
);

  // data-style storage applies to data frames and to stored remote frames
  logic data_rules;
  assign data_rules = ~is_remote_i | rmt_store_i;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic [3:0] code;
    logic       known;
    logic       free_data;
    logic       free_rmt;
    logic       is_free;

    assign code  = code_i[4*g +: 4];
    assign known = (code == MB_CODE_EMPTY) || (code == MB_CODE_FULL) ||
                   (code == MB_CODE_OVERRUN) || (code == MB_CODE_RANSWER);

    assign free_data = (code == MB_CODE_EMPTY) ||
                       (((code == MB_CODE_FULL) || (code == MB_CODE_OVERRUN)) &&
                        unlocked_i[g]);
    assign free_rmt  = (code == MB_CODE_RANSWER);
    assign is_free   = data_rules ? free_data : free_rmt;

    assign free_o[g] = match_i[g] & known & is_free;
    assign occ_o[g]  = match_i[g] & known & ~is_free;
  end

endmodule

// File: rtl/can_prio_find.sv
module can_prio_find #(
  parameter int NUM_MB   = 16,
  parameter bit FROM_LOW = 1'b1,
  localparam int IDX_W   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic [NUM_MB-1:0] hit_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);

  if (FROM_LOW) begin : g_low
    always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = NUM_MB - 1; i >= 0; i--) begin
        if (hit_i[i]) begin
          found_o = 1'b1;
          idx_o   = IDX_W'(i);
        end
      end
    end
  end else begin : g_high
    always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = 0; i < NUM_MB; i++) begin
        if (hit_i[i]) begin
          found_o = 1'b1;
          idx_o   = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/can_rx_winner_arb.sv
module can_rx_winner_arb
  import can_arb_pkg::*;
#(
  parameter int  NUM_MB = 16,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dlc_done_i,
  input  logic                is_remote_i,
  input  logic [NUM_MB-1:0]   mb_match_i,
  input  logic [4*NUM_MB-1:0] mb_code_i,
  input  logic [NUM_MB-1:0]   mb_unlocked_i,
  input  logic                fifo_en_i,
  input  logic                fifo_match_i,
  input  logic                fifo_full_i,
  input  logic                mb_first_i,
  input  logic                queue_en_i,
  input  logic                rmt_store_i,
  output logic                res_valid_o,
  output logic                win_mb_o,
  output logic [IDX_W-1:0]    win_idx_o,
  output logic                mb_ovr_o,
  output logic                win_fifo_o,
  output logic                fifo_ovf_o,
  output logic                drop_o
);

  logic [NUM_MB-1:0] free_vec;
  logic [NUM_MB-1:0] occ_vec;
  logic              any_free, any_occ_lo, any_occ_hi;
  logic [IDX_W-1:0]  free_idx, occ_lo_idx, occ_hi_idx;

  can_mb_classify #(.NUM_MB(NUM_MB)) i_classify (
    .match_i     (mb_match_i),
    .code_i      (mb_code_i),
    .unlocked_i  (mb_unlocked_i),
    .is_remote_i (is_remote_i),
    .rmt_store_i (rmt_store_i),
    .free_o      (free_vec),
    .occ_o       (occ_vec)
  );

  can_prio_find #(.NUM_MB(NUM_MB), .FROM_LOW(1'b1)) i_free_find (
    .hit_i (free_vec), .found_o (any_free), .idx_o (free_idx)
  );

  can_prio_find #(.NUM_MB(NUM_MB), .FROM_LOW(1'b1)) i_occ_lo_find (
    .hit_i (occ_vec), .found_o (any_occ_lo), .idx_o (occ_lo_idx)
  );

  can_prio_find #(.NUM_MB(NUM_MB), .FROM_LOW(1'b0)) i_occ_hi_find (
    .hit_i (occ_vec), .found_o (any_occ_hi), .idx_o (occ_hi_idx)
  );

  // ---------------- decision (next state) ----------------
  logic             fifo_hit;
  logic             fifo_ok;
  arb_out_e         dec_kind;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_ovr;

  assign fifo_hit = fifo_en_i & fifo_match_i;
  assign fifo_ok  = fifo_hit & ~fifo_full_i;

  always_comb begin
    dec_kind = OUT_DROP;
    dec_idx  = '0;
    dec_ovr  = 1'b0;
    if (!mb_first_i && fifo_ok) begin
      dec_kind = OUT_FIFO;
    end else if (any_free) begin
      dec_kind = OUT_MB;
      dec_idx  = free_idx;
    end else if (any_occ_lo) begin
      if (queue_en_i && fifo_ok) begin
        dec_kind = OUT_FIFO;
      end else begin
        dec_kind = OUT_MB;
        dec_ovr  = 1'b1;
        dec_idx  = queue_en_i ? occ_hi_idx : occ_lo_idx;
      end
    end else if (fifo_hit) begin
      dec_kind = fifo_full_i ? OUT_OVF : OUT_FIFO;
    end
  end

  arb_out_e         kind_d, kind_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             ovr_d, ovr_q;
  logic             vld_d, vld_q;
  logic             res_en;

  // result registers load on a trigger and on the cycle after, to clear
  assign res_en = dlc_done_i | vld_q;

  always_comb begin
    vld_d  = dlc_done_i;
    kind_d = dlc_done_i ? dec_kind : OUT_NONE;
    idx_d  = (dlc_done_i && dec_kind == OUT_MB) ? dec_idx : '0;
    ovr_d  = dlc_done_i & dec_ovr;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= OUT_NONE;
      idx_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (res_en) begin
      vld_q  <= vld_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
      ovr_q  <= ovr_d;
    end
  end

  assign res_valid_o = vld_q;
  assign win_mb_o    = (kind_q == OUT_MB);
  assign win_fifo_o  = (kind_q == OUT_FIFO);
  assign fifo_ovf_o  = (kind_q == OUT_OVF);
  assign drop_o      = (kind_q == OUT_DROP);
  assign win_idx_o   = idx_q;
  assign mb_ovr_o    = ovr_q;

  // ---------------- assertions ----------------
  a_r2_valid_follows_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    dlc_done_i |=> res_valid_o);

  a_r2_no_valid_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    !dlc_done_i |=> !res_valid_o);

  a_r2_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> !(win_mb_o || win_fifo_o || fifo_ovf_o || drop_o || mb_ovr_o));

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $countones({win_mb_o, win_fifo_o, fifo_ovf_o, drop_o}) == 1);

  a_r3_ovr_needs_mb: assert property (@(posedge clk) disable iff (!rst_n)
    mb_ovr_o |-> win_mb_o);

  a_r6_winner_matched: assert property (@(posedge clk) disable iff (!rst_n)
    win_mb_o |-> (($past(mb_match_i) >> win_idx_o) & 1) == 1);

  a_r9_overflow_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf_o |-> $past(fifo_full_i && fifo_match_i && fifo_en_i));

  a_r9_drop_fifo_missed: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(!(fifo_en_i && fifo_match_i)));

  a_r11_fifo_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    win_fifo_o |-> $past(fifo_en_i && fifo_match_i && !fifo_full_i));

endmodule

// File: tb/test_can_rx_winner_arb.sv
module test_can_rx_winner_arb;

  localparam int N  = 6;
  localparam int IW = $clog2(N);

  logic            clk, rst_n;
  logic            dlc_done, is_remote, fifo_en, fifo_match, fifo_full;
  logic            mb_first, queue_en, rmt_store;
  logic [N-1:0]    match, unlocked;
  logic [4*N-1:0]  codes;
  logic            res_valid, win_mb, mb_ovr, win_fifo, fifo_ovf, drop;
  logic [IW-1:0]   win_idx;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // expected for the next sample: kind 0 none,1 mb,2 fifo,3 ovf,4 drop
  int exp_kind = 0, exp_idx = 0, exp_ovr = 0;
  string exp_req = "R1";

  can_rx_winner_arb #(.NUM_MB(N)) i_can_rx_winner_arb (
    .clk(clk), .rst_n(rst_n), .dlc_done_i(dlc_done), .is_remote_i(is_remote),
    .mb_match_i(match), .mb_code_i(codes), .mb_unlocked_i(unlocked),
    .fifo_en_i(fifo_en), .fifo_match_i(fifo_match), .fifo_full_i(fifo_full),
    .mb_first_i(mb_first), .queue_en_i(queue_en), .rmt_store_i(rmt_store),
    .res_valid_o(res_valid), .win_mb_o(win_mb), .win_idx_o(win_idx),
    .mb_ovr_o(mb_ovr), .win_fifo_o(win_fifo), .fifo_ovf_o(fifo_ovf), .drop_o(drop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int code_of(int i);
    return int'(codes[4*i +: 4]);
  endfunction

  // behavioural reference for the inputs now on the pins
  task automatic model(input string req);
    int first_free = -1, first_occ = -1, last_occ = -1;
    bit fok;
    for (int i = 0; i < N; i++) begin
      int  c   = code_of(i);
      bit  fr;
      if (!match[i]) continue;
      if (c != 4 && c != 2 && c != 6 && c != 10) continue;
      if (!is_remote || rmt_store) fr = (c == 4) || ((c == 2 || c == 6) && unlocked[i]);
      else                         fr = (c == 10);
      if (fr) begin if (first_free < 0) first_free = i; end
      else begin
        if (first_occ < 0) first_occ = i;
        last_occ = i;
      end
    end
    fok = fifo_en && fifo_match && !fifo_full;
    exp_idx = 0; exp_ovr = 0; exp_req = req;
    if (!dlc_done)                    exp_kind = 0;
    else if (fifo_en && !mb_first && fok) exp_kind = 2;
    else if (first_free >= 0) begin exp_kind = 1; exp_idx = first_free; end
    else if (first_occ >= 0) begin
      if (queue_en && fok) exp_kind = 2;
      else begin
        exp_kind = 1; exp_ovr = 1;
        exp_idx = queue_en ? last_occ : first_occ;
      end
    end
    else if (fifo_en && fifo_match) exp_kind = fifo_full ? 3 : 2;
    else exp_kind = 4;
  endtask

  task automatic compare();
    int act_kind;
    bit bad;
    act_kind = win_mb ? 1 : win_fifo ? 2 : fifo_ovf ? 3 : drop ? 4 : 0;
    vectors++;
    bad = (res_valid != (exp_kind != 0)) || (act_kind != exp_kind) ||
          (int'(mb_ovr) != exp_ovr) || (win_mb && int'(win_idx) != exp_idx) ||
          ((win_mb + win_fifo + fifo_ovf + drop) > 1);
    if (bad) begin
      errors++;
      $display("FAIL %s: act vld=%0b kind=%0d idx=%0d ovr=%0b exp vld=%0b kind=%0d idx=%0d ovr=%0d",
               exp_req, res_valid, act_kind, win_idx, mb_ovr, exp_kind != 0,
               exp_kind, exp_idx, exp_ovr);
    end
  endtask

  // apply current inputs for one cycle and check the registered result
  task automatic step(input string req);
    model(req);
    @(negedge clk);
    compare();
  endtask

  task automatic set_all(input logic [N-1:0] m, input logic [3:0] c,
                         input logic [N-1:0] u);
    match = m; unlocked = u;
    for (int i = 0; i < N; i++) codes[4*i +: 4] = c;
  endtask

  task automatic cfg(input bit fe, fm, ff, mf, qe);
    fifo_en = fe; fifo_match = fm; fifo_full = ff; mb_first = mf; queue_en = qe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dlc_done = 0; is_remote = 0; rmt_store = 0;
    set_all('0, 4'h0, '0); cfg(0, 0, 0, 1, 0);
    // R1: reset state
    dlc_done = 1; set_all('1, 4'h4, '0);
    repeat (2) @(negedge clk);
    exp_kind = 0; exp_req = "R1"; compare();
    @(negedge clk); rst_n = 1'b1; dlc_done = 0;
    step("R2");

    // R6: lowest free wins, mailbox-first
    dlc_done = 1; cfg(1, 1, 0, 1, 0); set_all(6'b110100, 4'h4, '0);
    step("R6");
    // R4: FULL unlocked free vs locked occupied
    set_all(6'b001110, 4'h2, 6'b001000); step("R4");
    codes[4*1 +: 4] = 4'h6; step("R4");
    // R7: all occupied, queue off -> lowest overrun
    set_all(6'b011010, 4'h2, '0); step("R7");
    // R8: queue on, fifo ok -> fifo; fifo full -> highest overrun
    queue_en = 1; step("R8");
    fifo_full = 1; step("R8");
    fifo_en = 0; fifo_full = 0; step("R8");
    // R5: remote, no storage: only RANSWER free; bad codes ignored
    fifo_en = 1; queue_en = 0; is_remote = 1; set_all(6'b111111, 4'h4, '1);
    codes[4*4 +: 4] = 4'hA; step("R5");
    codes[4*4 +: 4] = 4'h2; step("R5");
    rmt_store = 1; step("R4");
    set_all(6'b111111, 4'h7, '1); fifo_match = 0; step("R5");
    is_remote = 0; rmt_store = 0;
    // R9: no mailbox match
    set_all('0, 4'h4, '0); cfg(1, 1, 0, 1, 0); step("R9");
    fifo_full = 1; step("R9");
    fifo_match = 0; step("R9");
    fifo_full = 0; step("R9");
    // R10: fifo-first wins over free mailbox
    set_all(6'b000001, 4'h4, '0); cfg(1, 1, 0, 0, 0); step("R10");
    fifo_full = 1; step("R10");
    // R11: fifo disabled ignores fifo inputs and priority
    cfg(0, 1, 0, 0, 0); set_all('0, 4'h4, '0); step("R11");
    set_all(6'b100000, 4'h2, '0); queue_en = 1; step("R11");
    // R2: back-to-back triggers, then idle
    set_all(6'b000010, 4'h4, '0); step("R2");
    set_all(6'b000100, 4'h4, '0); step("R2");
    dlc_done = 0; step("R2");
    step("R2");

    // random streams
    for (int n = 0; n < 4000; n++) begin
      dlc_done   = ($urandom_range(0, 3) != 0);
      is_remote  = $urandom_range(0, 1);
      rmt_store  = $urandom_range(0, 1);
      fifo_en    = $urandom_range(0, 1);
      fifo_match = $urandom_range(0, 1);
      fifo_full  = $urandom_range(0, 1);
      mb_first   = $urandom_range(0, 1);
      queue_en   = $urandom_range(0, 1);
      match      = N'($urandom) & N'($urandom);
      unlocked   = N'($urandom);
      for (int i = 0; i < N; i++) begin
        case ($urandom_range(0, 5))
          0: codes[4*i +: 4] = 4'h4;
          1: codes[4*i +: 4] = 4'h2;
          2: codes[4*i +: 4] = 4'h6;
          3: codes[4*i +: 4] = 4'hA;
          default: codes[4*i +: 4] = 4'($urandom);
        endcase
      end
      step("R3");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule